// File: doc/BRIEF.md
# DMA Bus Arbitration and Handshake Responder

This block lives on the host side of an active-low, asynchronous system interface that connects to a network coprocessor. The coprocessor can take the bus for DMA, and the host can also reach it directly. The block samples the coprocessor's bus request through a synchronizer and answers with a bus grant. It acknowledges each DMA data beat without inserting wait states. When a higher-priority agent needs the bus, it can ask the coprocessor to give the bus back. It can also end a beat with a bus error, either alone (abort) or together with halt (rerun the last beat).

For direct host reads and writes, the block drives the coprocessor's chip select. It also owns the direction of the shared transfer-acknowledge line. The block drives that line at all times except during a direct access, when the coprocessor answers on it. The driver is released for one clock before chip select falls, so the two sides never drive the line together. The block also qualifies the external data-buffer enable. It produces a divided system bus clock, which software or power-down can park high.

Top module: `dma_bus_arbiter`

## Requirements
- R1: `breq_n` passes through SYNC_STAGES flip-flops before the arbiter uses it. With the default of 2 stages, a fall of `breq_n` shows as `bgr_n` low on the third rising clock edge after the change, and not earlier.
- R2: `bgr_n` is high (not granted) when idle and low while the bus is granted. After `breq_n` returns high, `bgr_n` returns high on the third rising edge, which is one clock after the synchronised request drops.
- R3: While granted, a low `strobe_n` marks a DMA beat. `ack_out_n` goes low on the third rising edge after `strobe_n` falls, with no wait state, and returns high once the synchronised strobe is high again.
- R4: `brls_n` goes low only while granted and only outside a beat: a high `hp_req` during a beat leaves `brls_n` high until the beat ends. While idle, `hp_req` has no effect on `brls_n` or `bgr_n`.
- R5: `err_abort` during a beat ends it with `berr_n` low, `halt_n` high and `ack_out_n` high, until `strobe_n` returns high.
- R6: `err_retry` during a beat drives `berr_n` and `halt_n` low together (rerun). `halt_n` is never low without `berr_n` low.
- R7: `ack_oe` is 1 (the block drives the acknowledge line) at all times except during a direct-access sequence. It is never 0 while the bus is granted.
- R8: When `host_req` is seen while idle, `ack_oe` falls on the next edge and `cs_n` falls one edge later. `cs_n` stays low until the synchronised `ack_in_n` is low. Then `cs_n` rises and `host_done` pulses for one clock, and `ack_oe` returns to 1 one clock after that.
- R9: A direct access never starts while the bus is granted, and no grant is issued while a direct access is in progress. The grant follows on the second edge after the access completes.
- R10: `buf_oe` equals the inverse of `dben_n` while the bus is granted or `cs_n` is low, and is 0 otherwise.
- R11: `sysclk` toggles every CLK_DIV clocks. It is held high from the next edge while `clk_hold` or `pwr_dn` is high.
- R12: During reset, `bgr_n`, `brls_n`, `ack_out_n`, `berr_n`, `halt_n`, `cs_n`, `ack_oe` and `sysclk` are 1, and `host_done` and `buf_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| breq_n | input | 1 | Coprocessor bus request, active-low, asynchronous |
| strobe_n | input | 1 | Coprocessor DMA beat strobe, active-low, asynchronous |
| hp_req | input | 1 | A higher-priority agent wants the bus |
| err_abort | input | 1 | End the current beat with a bus error |
| err_retry | input | 1 | End the current beat with bus error plus halt (rerun) |
| host_req | input | 1 | Host wants a direct access (level) |
| host_done | output | 1 | One-clock pulse when the direct access is acknowledged |
| cs_n | output | 1 | Coprocessor chip select, active-low |
| ack_in_n | input | 1 | Acknowledge line as seen at the pin |
| ack_out_n | output | 1 | Acknowledge value driven when `ack_oe` is 1 |
| ack_oe | output | 1 | 1: block drives the acknowledge line; 0: line is an input |
| bgr_n | output | 1 | Bus grant, active-low |
| brls_n | output | 1 | Bus release request, active-low |
| berr_n | output | 1 | Bus error, active-low |
| halt_n | output | 1 | Halt, active-low; with bus error it requests a rerun |
| dben_n | input | 1 | Data-buffer enable request, active-low |
| buf_oe | output | 1 | External data buffers drive when 1 |
| clk_hold | input | 1 | Software request to park the system clock high |
| pwr_dn | input | 1 | Power-down; parks the system clock high |
| sysclk | output | 1 | Divided system bus clock |

## Verification
The embedded assertions watch the rules that must hold on every cycle:
- the release request appears only under a grant;
- halt never appears without bus error;
- no acknowledge is given during an error ending;
- the acknowledge driver is off whenever chip select is low, and for a clock before it falls;
- chip select and grant are never active together;
- the grant drops one clock after the synchronised request does;
- the system clock stays parked while it is held.

Only the bench scenarios can show the exact synchronizer latency of grant and acknowledge. They also show that a release request waits for the beat boundary, and that `hp_req` is ignored while idle. The remaining scenario checks cover the full direct-access handshake timing and the clock division ratio.

// File: rtl/dab_pkg.sv
package dab_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_GRANTED,
        ARB_DMA_CYCLE,
        ARB_RELEASE_PENDING,
        ARB_ERROR_END
    } arb_state_e;

    typedef enum logic [1:0] {
        DA_IDLE,
        DA_TURN,
        DA_SELECT,
        DA_DONE
    } da_state_e;

    // Active-low bus pins owned by the arbiter
    typedef struct packed {
        logic bgr_n;
        logic brls_n;
        logic ack_n;
        logic berr_n;
        logic halt_n;
    } dma_pins_t;

    localparam dma_pins_t PINS_QUIET = '1;

    function automatic dma_pins_t arb_decode(arb_state_e s, logic retry);
        dma_pins_t p;
        p = PINS_QUIET;
        case (s)
            ARB_GRANTED:         p.bgr_n = 1'b0;
            ARB_DMA_CYCLE: begin
                p.bgr_n = 1'b0;
                p.ack_n = 1'b0;
            end
            ARB_RELEASE_PENDING: begin
                p.bgr_n  = 1'b0;
                p.brls_n = 1'b0;
            end
            ARB_ERROR_END: begin
                p.bgr_n  = 1'b0;
                p.berr_n = 1'b0;
                p.halt_n = ~retry;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dab_sync.sv
module dab_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[g] <= '1;
                end else if (g == 0) begin
                    stg[g] <= d;
                end else begin
                    stg[g] <= stg[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dab_arbiter.sv
module dab_arbiter
    import dab_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      strobe,
    input  logic      hp_req,
    input  logic      err_abort,
    input  logic      err_retry,
    input  logic      dir_busy,
    output dma_pins_t pins,
    output logic      granted
);
    arb_state_e state, nxt;
    logic       retry_q;

    always_comb begin
        nxt = state;
        case (state)
            ARB_IDLE:
                if (req && !dir_busy) nxt = ARB_GRANTED;
            ARB_GRANTED:
                if (!req)        nxt = ARB_IDLE;
                else if (strobe) nxt = ARB_DMA_CYCLE;
                else if (hp_req) nxt = ARB_RELEASE_PENDING;
            ARB_DMA_CYCLE:
                if (!req)                        nxt = ARB_IDLE;
                else if (err_abort || err_retry) nxt = ARB_ERROR_END;
                else if (!strobe)                nxt = hp_req ? ARB_RELEASE_PENDING : ARB_GRANTED;
            ARB_RELEASE_PENDING:
                if (!req)        nxt = ARB_IDLE;
                else if (strobe) nxt = ARB_DMA_CYCLE;
            ARB_ERROR_END:
                if (!req)         nxt = ARB_IDLE;
                else if (!strobe) nxt = ARB_GRANTED;
            default: nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ARB_IDLE;
            retry_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ARB_DMA_CYCLE && nxt == ARB_ERROR_END)
                retry_q <= err_retry;
        end
    end

    assign pins    = arb_decode(state, retry_q);
    assign granted = (state != ARB_IDLE);

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
        (!req && !pins.bgr_n) |=> pins.bgr_n);                   // R2
    AST_RLS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        !pins.brls_n |-> !pins.bgr_n);                           // R4
    AST_NO_ACK_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        !pins.berr_n |-> pins.ack_n);                            // R5
    AST_HALT_NEEDS_BERR: assert property (@(posedge clk) disable iff (rst)
        !pins.halt_n |-> !pins.berr_n);                          // R6
endmodule

// File: rtl/dab_direct.sv
module dab_direct
    import dab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic arb_idle,
    input  logic bus_req,
    input  logic ack_seen,
    output logic cs_n,
    output logic ack_oe,
    output logic host_done,
    output logic busy
);
    da_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= DA_IDLE;
        end else begin
            case (st)
                DA_IDLE:   if (host_req && arb_idle && !bus_req) st <= DA_TURN;
                DA_TURN:   st <= DA_SELECT;
                DA_SELECT: if (ack_seen) st <= DA_DONE;
                DA_DONE:   st <= DA_IDLE;
                default:   st <= DA_IDLE;
            endcase
        end
    end

    assign cs_n      = (st != DA_SELECT);
    assign ack_oe    = (st == DA_IDLE);
    assign host_done = (st == DA_DONE);
    assign busy      = (st != DA_IDLE);
endmodule

// File: rtl/dab_sysclk.sv
module dab_sysclk #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic park,
    output logic sysclk
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || park) begin
            cnt    <= '0;
            sysclk <= 1'b1;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            sysclk <= ~sysclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        park |=> sysclk);                                        // R11
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dab_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_DIV     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic breq_n,
    input  logic strobe_n,
    input  logic hp_req,
    input  logic err_abort,
    input  logic err_retry,
    input  logic host_req,
    output logic host_done,
    output logic cs_n,
    input  logic ack_in_n,
    output logic ack_out_n,
    output logic ack_oe,
    output logic bgr_n,
    output logic brls_n,
    output logic berr_n,
    output logic halt_n,
    input  logic dben_n,
    output logic buf_oe,
    input  logic clk_hold,
    input  logic pwr_dn,
    output logic sysclk
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_n, syn_n;
    dma_pins_t        pins;
    logic             granted, dir_busy;

    assign raw_n = {breq_n, strobe_n, ack_in_n};

    dab_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_n),
        .q   (syn_n)
    );

    dab_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (~syn_n[2]),
        .strobe    (~syn_n[1]),
        .hp_req    (hp_req),
        .err_abort (err_abort),
        .err_retry (err_retry),
        .dir_busy  (dir_busy),
        .pins      (pins),
        .granted   (granted)
    );

    dab_direct u_dir (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .arb_idle  (~granted),
        .bus_req   (~syn_n[2]),
        .ack_seen  (~syn_n[0]),
        .cs_n      (cs_n),
        .ack_oe    (ack_oe),
        .host_done (host_done),
        .busy      (dir_busy)
    );

    dab_sysclk #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .park   (clk_hold | pwr_dn),
        .sysclk (sysclk)
    );

    assign bgr_n     = pins.bgr_n;
    assign brls_n    = pins.brls_n;
    assign ack_out_n = pins.ack_n;
    assign berr_n    = pins.berr_n;
    assign halt_n    = pins.halt_n;
    assign buf_oe    = ~dben_n & (granted | ~cs_n);

    AST_ACK_INPUT_ONLY_DIRECT: assert property (@(posedge clk) disable iff (rst)
        !ack_oe |-> bgr_n);                                      // R7
    AST_ACK_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(!ack_oe));                         // R8
    AST_CS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !ack_oe);                                      // R8
    AST_CS_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> bgr_n);                                        // R9
endmodule

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
    logic clk = 1'b0;
    logic rst;
    logic breq_n, strobe_n, hp_req, err_abort, err_retry, host_req;
    logic host_done, cs_n, ack_out_n, ack_oe, bgr_n, brls_n, berr_n, halt_n;
    logic dben_n, buf_oe, clk_hold, pwr_dn, sysclk;
    logic cop_ack_n;
    logic ack_pin;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    assign ack_pin = ack_oe ? ack_out_n : cop_ack_n;

    dma_bus_arbiter uut (
        .clk(clk), .rst(rst), .breq_n(breq_n), .strobe_n(strobe_n),
        .hp_req(hp_req), .err_abort(err_abort), .err_retry(err_retry),
        .host_req(host_req), .host_done(host_done), .cs_n(cs_n),
        .ack_in_n(ack_pin), .ack_out_n(ack_out_n), .ack_oe(ack_oe),
        .bgr_n(bgr_n), .brls_n(brls_n), .berr_n(berr_n), .halt_n(halt_n),
        .dben_n(dben_n), .buf_oe(buf_oe), .clk_hold(clk_hold),
        .pwr_dn(pwr_dn), .sysclk(sysclk)
    );

    // {breq_n, strobe_n, hp_req, err_abort, err_retry,
    //  exp bgr_n, brls_n, ack_out_n, berr_n, halt_n}
    localparam logic [9:0] VEC [14] = '{
        10'b11000_11111,   // idle
        10'b11100_11111,   // hp_req while idle: no effect (R4)
        10'b01000_01111,   // granted
        10'b00000_01011,   // beat acknowledged (R3)
        10'b01000_01111,   // beat over
        10'b00010_01101,   // abort (R5)
        10'b01000_01111,
        10'b00001_01100,   // retry (R6)
        10'b01000_01111,
        10'b00000_01011,   // beat
        10'b00100_01011,   // hp_req mid-beat: release waits (R4)
        10'b01100_00111,   // boundary: release (R4)
        10'b11100_11111,   // request removed
        10'b11000_11111
    };

    function automatic string row_tag(int i);
        case (i)
            1, 10, 11: return "R4";
            3, 9:      return "R3";
            5:         return "R5";
            7:         return "R6";
            default:   return "R2";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int toggles;
        int ones;
        logic prev;
        rst = 1'b1; breq_n = 1'b1; strobe_n = 1'b1; hp_req = 1'b0;
        err_abort = 1'b0; err_retry = 1'b0; host_req = 1'b0;
        dben_n = 1'b1; clk_hold = 1'b0; pwr_dn = 1'b0; cop_ack_n = 1'b1;
        ticks(3);
        // R12 reset state
        chk("R12", "bus pins", {bgr_n, brls_n, ack_out_n, berr_n, halt_n}, 5'b11111);
        chk("R12", "cs/oe/done/buf/clk", {cs_n, ack_oe, host_done, buf_oe, sysclk}, 5'b11001);
        rst = 1'b0;
        ticks(2);

        // R1 grant latency through the synchronizer
        breq_n = 1'b0;
        ticks(2);
        chk("R1", "bgr_n before 3rd edge", bgr_n, 1'b1);
        ticks(1);
        chk("R1", "bgr_n at 3rd edge", bgr_n, 1'b0);
        // R2 grant release latency
        breq_n = 1'b1;
        ticks(2);
        chk("R2", "bgr_n held before 3rd edge", bgr_n, 1'b0);
        ticks(1);
        chk("R2", "bgr_n released", bgr_n, 1'b1);
        ticks(1);

        // vector table
        for (int i = 0; i < 14; i++) begin
            {breq_n, strobe_n, hp_req, err_abort, err_retry} = VEC[i][9:5];
            ticks(4);
            chk(row_tag(i), $sformatf("table row %0d", i),
                {bgr_n, brls_n, ack_out_n, berr_n, halt_n}, VEC[i][4:0]);
        end

        // R10 buffer enable qualification
        dben_n = 1'b0;
        #1;
        chk("R10", "buf_oe idle", buf_oe, 1'b0);
        breq_n = 1'b0;
        ticks(4);
        chk("R10", "buf_oe granted", buf_oe, 1'b1);
        dben_n = 1'b1;
        #1;
        chk("R10", "buf_oe dben high", buf_oe, 1'b0);

        // R9 no direct access while granted; R7 ack stays driven
        ticks(1);
        host_req = 1'b1;
        ticks(4);
        chk("R9", "cs_n while granted", cs_n, 1'b1);
        chk("R7", "ack_oe while granted", ack_oe, 1'b1);
        host_req = 1'b0;
        breq_n = 1'b1;
        ticks(4);

        // R8 direct access handshake
        host_req = 1'b1;
        ticks(1);
        chk("R8", "turnaround {ack_oe,cs_n}", {ack_oe, cs_n}, 2'b01);
        ticks(1);
        chk("R8", "select {ack_oe,cs_n}", {ack_oe, cs_n}, 2'b00);
        breq_n = 1'b0;
        ticks(4);
        chk("R9", "no grant during access", bgr_n, 1'b1);
        host_req = 1'b0;
        cop_ack_n = 1'b0;
        ticks(2);
        chk("R8", "cs_n waits for synced ack", cs_n, 1'b0);
        ticks(1);
        chk("R8", "done {cs_n,host_done,ack_oe}", {cs_n, host_done, ack_oe}, 3'b110);
        cop_ack_n = 1'b1;
        ticks(1);
        chk("R8", "restore {host_done,ack_oe}", {host_done, ack_oe}, 2'b01);
        chk("R9", "grant not yet", bgr_n, 1'b1);
        ticks(1);
        chk("R9", "grant after access", bgr_n, 1'b0);
        breq_n = 1'b1;
        ticks(4);

        // R11 clock divider and parking
        prev = sysclk;
        toggles = 0;
        for (int k = 0; k < 8; k++) begin
            ticks(1);
            if (sysclk !== prev) toggles++;
            prev = sysclk;
        end
        chk("R11", "toggles in 8 clocks", toggles, 4);
        clk_hold = 1'b1;
        ticks(1);
        ones = 0;
        for (int k = 0; k < 6; k++) begin
            ticks(1);
            if (sysclk === 1'b1) ones++;
        end
        chk("R11", "parked by clk_hold", ones, 6);
        clk_hold = 1'b0;
        ticks(3);
        pwr_dn = 1'b1;
        ticks(1);
        ones = 0;
        for (int k = 0; k < 6; k++) begin
            ticks(1);
            if (sysclk === 1'b1) ones++;
        end
        chk("R11", "parked by pwr_dn", ones, 6);
        pwr_dn = 1'b0;
        ticks(2);

        finish_run();
    end
endmodule